// File: doc/BRIEF.md
# Debug and Monitor Access Trap Unit

This block makes the trap decision for one system-register access to debug, trace or performance-monitor state. It sits beside the instruction decode of a processor that runs under a hypervisor. Each cycle it receives the hypervisor's debug trap controls and a description of the access: privilege level, security state, whether the hypervisor is enabled, whether the core is in debug state, the access kind and a register-class code. It returns a single trap flag and the syndrome class to report. It also returns the effective values of the debug trap controls after the routing overrides have been applied.

The unit is purely combinational. Two things can force several debug trap controls to act as 1 without changing the stored control word: the debug-exception routing control, and a trap-general-exceptions input. Debug state suppresses traps on the comms-channel data registers. The syndrome depends only on whether the access was a register transfer or a load/store.

Top module: `dbgtrap_unit`

## Requirements
- R1: No trap is raised and the syndrome is 0 when any of these holds: the access is secure (`secure_i`=1), the hypervisor is not enabled (`hyp_en_i`=0), or the privilege level `pl_i` is 2 or 3.
- R2: The effective routing bit (`eff_o[3]`) equals routing control `ctl_i[5]` OR `tge_i`.
- R3: The effective ROM-address (`eff_o[0]`), OS/powerdown (`eff_o[1]`) and debug-register (`eff_o[2]`) bits each equal their stored control (`ctl_i[2]`, `ctl_i[3]`, `ctl_i[4]`) OR the effective routing bit. `ctl_i` itself is never modified.
- R4: Class 0 (comms-channel data) traps at levels 0 and 1 when `ctl_i[0]` or the effective debug-register bit is 1. It never traps while `dbg_state_i`=1.
- R5: Class 1 (ROM address) traps at levels 0 and 1 when the effective ROM-address bit is 1.
- R6: Class 2 (OS/powerdown) traps only at level 1, when the effective OS/powerdown bit is 1. It never traps at level 0.
- R7: Class 3 (other debug) traps at levels 0 and 1 when the effective debug-register bit is 1. That bit alone, with routing and `tge_i` at 0, traps neither class 1 nor class 2.
- R8: Class 4 (trace filter) traps only at level 1, when `ctl_i[1]` is 1.
- R9: Class 5 (monitor control) traps when `ctl_i[6]` or `ctl_i[7]` is 1, unless `usr_trap_i`=1, in which case it does not trap here.
- R10: Class 6 (other monitor) traps when `ctl_i[6]` is 1. Class 7 never traps.
- R11: When trapped, `syn_o` is 0x05 for a register transfer (`kind_i`=0) and 0x06 for a load/store (`kind_i`=1). Otherwise `syn_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_i | input | 8 | Stored controls: [0] comms, [1] trace filter, [2] ROM addr, [3] OS/powerdown, [4] debug regs, [5] routing, [6] all monitor, [7] monitor control |
| tge_i | input | 1 | Trap-general-exceptions |
| pl_i | input | 2 | Privilege level 0..3 |
| secure_i | input | 1 | Access is in secure state |
| hyp_en_i | input | 1 | Hypervisor enabled in current security state |
| dbg_state_i | input | 1 | Core is in debug state |
| usr_trap_i | input | 1 | Lower-level user-enable trap already taken |
| kind_i | input | 1 | 0 register transfer, 1 load/store |
| cls_i | input | 3 | Register class code 0..7 |
| trap_o | output | 1 | Access traps to hypervisor |
| syn_o | output | 6 | Syndrome class |
| eff_o | output | 4 | Effective bits: [0] ROM, [1] OS, [2] debug, [3] routing |

## Verification
Directed patterns come first. They isolate each override. One vector sets only the debug-register control, which separates the class 3 trap from the ROM and OS classes. Another sets only `tge_i`, which shows that forcing reaches every debug class while the stored word stays untouched. Debug state and `usr_trap_i` are toggled on otherwise trapping accesses to expose their suppression, and level 0 is paired with the level-1-only classes. A long run of random vectors then compares every output against a behavioural model each clock, covering the interactions between the gating, the forcing and the access kind.

// File: rtl/dbgtrap_pkg.sv
package dbgtrap_pkg;

    localparam int CLS_W   = 3;
    localparam int NUM_CLS = 1 << CLS_W;
    localparam int CTL_W   = 8;
    localparam int EFF_W   = 4;
    localparam int SYN_W   = 6;
    localparam logic [SYN_W-1:0] SYN_XFER = SYN_W'(6'h05);
    localparam logic [SYN_W-1:0] SYN_LDST = SYN_W'(6'h06);

    typedef enum logic [1:0] {PL0, PL1, PL2, PL3} priv_e;
    typedef enum logic {ACC_XFER, ACC_LDST} acc_e;
    typedef enum logic [CLS_W-1:0] {
        CLS_COMMS, CLS_ROM, CLS_OSPWR, CLS_DEBUG,
        CLS_TRACEFLT, CLS_MONCTL, CLS_MONOTHER, CLS_NONE
    } cls_e;

    typedef struct packed {
        logic monctl;
        logic mon;
        logic route;
        logic dbg;
        logic os;
        logic rom;
        logic trace;
        logic comms;
    } ctl_t;

    typedef struct packed {
        logic route;
        logic dbg;
        logic os;
        logic rom;
    } eff_t;

    typedef struct packed {
        logic  secure;
        logic  hyp_en;
        logic  dbg_state;
        logic  usr_trap;
        priv_e pl;
    } ctx_t;

    // Per-class trap rule, before the common security/level gate.
    function automatic logic class_hit(cls_e c, ctl_t ctl, eff_t eff, ctx_t ctx);
        logic hit;
        case (c)
            CLS_COMMS:    hit = (ctl.comms | eff.dbg) & ~ctx.dbg_state;
            CLS_ROM:      hit = eff.rom;
            CLS_OSPWR:    hit = eff.os & (ctx.pl == PL1);
            CLS_DEBUG:    hit = eff.dbg;
            CLS_TRACEFLT: hit = ctl.trace & (ctx.pl == PL1);
            CLS_MONCTL:   hit = (ctl.mon | ctl.monctl) & ~ctx.usr_trap;
            CLS_MONOTHER: hit = ctl.mon;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [SYN_W-1:0] syn_code(acc_e k);
        return (k == ACC_LDST) ? SYN_LDST : SYN_XFER;
    endfunction

endpackage

// File: rtl/dbgtrap_force.sv
module dbgtrap_force
    import dbgtrap_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic tge_i,
    output eff_t eff_o
);
    logic route_eff;

    always_comb begin
        route_eff   = ctl_i.route | tge_i;
        eff_o.route = route_eff;
        eff_o.rom   = ctl_i.rom | route_eff;
        eff_o.os    = ctl_i.os  | route_eff;
        eff_o.dbg   = ctl_i.dbg | route_eff;
    end
endmodule

// File: rtl/dbgtrap_match.sv
module dbgtrap_match
    import dbgtrap_pkg::*;
#(
    parameter int N_CLS = NUM_CLS
) (
    input  ctl_t                    ctl_i,
    input  eff_t                    eff_i,
    input  ctx_t                    ctx_i,
    input  logic [$clog2(N_CLS)-1:0] cls_i,
    output logic                    hit_o
);
    localparam int IDX_W = $clog2(N_CLS);

    logic [N_CLS-1:0] hit_vec;
    logic             gate;

    for (genvar gi = 0; gi < N_CLS; gi++) begin : g_cls
        assign hit_vec[gi] = class_hit(cls_e'(CLS_W'(gi)), ctl_i, eff_i, ctx_i);
    end

    always_comb begin
        gate  = ~ctx_i.secure & ctx_i.hyp_en &
                ((ctx_i.pl == PL0) | (ctx_i.pl == PL1));
        hit_o = gate & hit_vec[IDX_W'(cls_i)];
    end
endmodule

// File: rtl/dbgtrap_syndrome.sv
module dbgtrap_syndrome
    import dbgtrap_pkg::*;
(
    input  logic             trap_i,
    input  acc_e             kind_i,
    output logic [SYN_W-1:0] syn_o
);
    always_comb syn_o = trap_i ? syn_code(kind_i) : '0;
endmodule

// File: rtl/dbgtrap_unit.sv
module dbgtrap_unit
    import dbgtrap_pkg::*;
(
    input  logic [7:0] ctl_i,
    input  logic       tge_i,
    input  logic [1:0] pl_i,
    input  logic       secure_i,
    input  logic       hyp_en_i,
    input  logic       dbg_state_i,
    input  logic       usr_trap_i,
    input  logic       kind_i,
    input  logic [2:0] cls_i,
    output logic       trap_o,
    output logic [5:0] syn_o,
    output logic [3:0] eff_o
);
    ctl_t ctl;
    eff_t eff;
    ctx_t ctx;
    logic hit;
    logic [SYN_W-1:0] syn;

    always_comb begin
        ctl           = ctl_t'(ctl_i);
        ctx.secure    = secure_i;
        ctx.hyp_en    = hyp_en_i;
        ctx.dbg_state = dbg_state_i;
        ctx.usr_trap  = usr_trap_i;
        ctx.pl        = priv_e'(pl_i);
    end

    dbgtrap_force u_force (
        .ctl_i (ctl),
        .tge_i (tge_i),
        .eff_o (eff)
    );

    dbgtrap_match #(.N_CLS(NUM_CLS)) u_match (
        .ctl_i (ctl),
        .eff_i (eff),
        .ctx_i (ctx),
        .cls_i (cls_i),
        .hit_o (hit)
    );

    dbgtrap_syndrome u_syn (
        .trap_i (hit),
        .kind_i (acc_e'(kind_i)),
        .syn_o  (syn)
    );

    assign trap_o = hit;
    assign syn_o  = syn;
    assign eff_o  = eff;

    // Checks across the force, match and syndrome pieces.
    always_comb begin
        if (secure_i || !hyp_en_i || pl_i[1])
            assert_gate_R1: assert (!trap_o);
        if (tge_i)
            assert_tge_route_R2: assert (eff_o[3]);
        if (eff_o[3])
            assert_force_R3: assert (eff_o[2:0] == 3'b111);
        if (dbg_state_i && cls_i == 3'd0)
            assert_dbgstate_R4: assert (!trap_o);
        if (pl_i == 2'd0 && cls_i == 3'd2)
            assert_os_pl0_R6: assert (!trap_o);
        if (cls_i == 3'd7)
            assert_none_R10: assert (!trap_o);
        assert_syn_R11: assert (trap_o ? (syn_o == 6'h05 || syn_o == 6'h06) : (syn_o == 6'h00));
    end
endmodule

// File: tb/dbgtrap_unit_test.sv
`timescale 1ns/1ps
module dbgtrap_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0] ctl;
    logic       tge, sec, hen, dst, utr, kind;
    logic [1:0] pl;
    logic [2:0] cls;
    logic       trap;
    logic [5:0] syn;
    logic [3:0] eff;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    dbgtrap_unit uut (
        .ctl_i(ctl), .tge_i(tge), .pl_i(pl), .secure_i(sec),
        .hyp_en_i(hen), .dbg_state_i(dst), .usr_trap_i(utr),
        .kind_i(kind), .cls_i(cls), .trap_o(trap), .syn_o(syn), .eff_o(eff)
    );

    task automatic cmp(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (ctl=%h tge=%0d pl=%0d sec=%0d hen=%0d dst=%0d utr=%0d kind=%0d cls=%0d)",
                     req, act, exp, ctl, tge, pl, sec, hen, dst, utr, kind, cls);
        end
    endtask

    // Behavioural reference: returns expected trap, syndrome, effective bits, and the tag.
    task automatic model(output bit e_trap, output int e_syn, output int e_eff, output string tag);
        bit route, rom, os, dbg, lowpl;
        route = ctl[5] || tge;
        rom   = ctl[2] || route;
        os    = ctl[3] || route;
        dbg   = ctl[4] || route;
        e_eff = {route, dbg, os, rom};
        lowpl = (pl == 0) || (pl == 1);
        e_trap = 0;
        if (sec || !hen || !lowpl) tag = "R1";
        else begin
            case (cls)
                0: begin tag = "R4";  e_trap = (ctl[0] || dbg) && !dst; end
                1: begin tag = "R5";  e_trap = rom; end
                2: begin tag = "R6";  e_trap = os && pl == 1; end
                3: begin tag = "R7";  e_trap = dbg; end
                4: begin tag = "R8";  e_trap = ctl[1] && pl == 1; end
                5: begin tag = "R9";  e_trap = (ctl[6] || ctl[7]) && !utr; end
                6: begin tag = "R10"; e_trap = ctl[6]; end
                default: begin tag = "R10"; e_trap = 0; end
            endcase
        end
        e_syn = !e_trap ? 0 : (kind ? 6 : 5);
    endtask

    task automatic step_check();
        bit    et;
        int    es, ee;
        string tg;
        #1;
        model(et, es, ee, tg);
        cmp(tg, int'(trap), int'(et));
        cmp("R11", int'(syn), es);
        cmp("R2", int'(eff[3]), ee >> 3);
        cmp("R3", int'(eff[2:0]), ee & 7);
    endtask

    task automatic drive(logic [7:0] c, logic t, logic [1:0] p, logic s, logic h,
                         logic d, logic u, logic k, logic [2:0] cl);
        @(negedge clk);
        ctl = c; tge = t; pl = p; sec = s; hen = h; dst = d; utr = u; kind = k; cls = cl;
        step_check();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        ctl = '0; tge = 0; pl = 0; sec = 0; hen = 0; dst = 0; utr = 0; kind = 0; cls = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // quiet state after reset: nothing traps, syndrome 0 (R1, R11)
        @(negedge clk); #1;
        cmp("R1", int'(trap), 0);
        cmp("R11", int'(syn), 0);
        cmp("R3", int'(eff), 0);
        // R7: debug bit alone traps class 3, not 1 or 2
        drive(8'h10, 0, 2'd1, 0, 1, 0, 0, 0, 3'd3);
        drive(8'h10, 0, 2'd1, 0, 1, 0, 0, 0, 3'd1);
        drive(8'h10, 0, 2'd1, 0, 1, 0, 0, 0, 3'd2);
        // R2/R3: tge forces all debug classes; ctl untouched
        drive(8'h00, 1, 2'd1, 0, 1, 0, 0, 0, 3'd1);
        drive(8'h00, 1, 2'd1, 0, 1, 0, 0, 1, 3'd2);
        cmp("R3", int'(ctl), 0);
        // R4: debug state suppresses comms trap
        drive(8'h01, 0, 2'd0, 0, 1, 0, 0, 1, 3'd0);
        drive(8'h01, 0, 2'd0, 0, 1, 1, 0, 1, 3'd0);
        // R6 / R8: level 0 excluded
        drive(8'h08, 0, 2'd0, 0, 1, 0, 0, 0, 3'd2);
        drive(8'h02, 0, 2'd0, 0, 1, 0, 0, 0, 3'd4);
        drive(8'h02, 0, 2'd1, 0, 1, 0, 0, 0, 3'd4);
        // R9: user-enable trap overrides monitor-control trap
        drive(8'h80, 0, 2'd0, 0, 1, 0, 0, 0, 3'd5);
        drive(8'h80, 0, 2'd0, 0, 1, 0, 1, 0, 3'd5);
        // R10: other monitor, class 7
        drive(8'h40, 0, 2'd1, 0, 1, 0, 0, 0, 3'd6);
        drive(8'hFF, 1, 2'd1, 0, 1, 0, 0, 0, 3'd7);
        // R1: secure, level 2, hypervisor off
        drive(8'hFF, 1, 2'd1, 1, 1, 0, 0, 0, 3'd3);
        drive(8'hFF, 1, 2'd2, 0, 1, 0, 0, 0, 3'd3);
        drive(8'hFF, 1, 2'd1, 0, 0, 0, 0, 0, 3'd3);
        // random sweep compared against the model each clock
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[7:0], r[8], r[10:9], (r[13:11] == 0), (r[16:14] != 0),
                  r[17], r[18], r[19], r[22:20]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule